// File: doc/BRIEF.md
# Segmented Instruction Cache

This block sits between a processor's instruction fetch port and a slow external program memory. It holds up to 128 instruction words in four segments of 32 words each. Each segment can hold any 32-word-aligned block of the external address space. The CPU presents a fetch with `fetch_valid` and `fetch_addr` and waits until `fetch_ready` is high. A hit returns the word in the same cycle. A miss reads the word from external memory, passes it to the CPU, and keeps a copy in the cache. Fetches below the internal region limit go to internal memory through a separate port and never touch the cache.

Each segment holds a tag, which is the word address without its low five bits, and one present bit per word. Segments fill one word at a time, as the program actually fetches those words. When a miss needs a new segment, the least recently used segment that is not frozen is reused. Software can freeze any segment through the `freeze` inputs. A frozen segment still serves hits, but it is never chosen for replacement. A one-cycle `clear` pulse empties the whole cache.

The control is a two-state machine:
- **LOOKUP**: serves hits and internal fetches.
- **REFILL**: holds an external read open.

Transitions:
- LOOKUP→REFILL on an external fetch that misses.
- LOOKUP→LOOKUP on a hit, on an internal fetch, or when no fetch is presented.
- REFILL→REFILL while `ext_ready` is low.
- REFILL→LOOKUP in the cycle `ext_ready` is high.

Top module: `icache_seg`

## Requirements
- R1: A fetch with address below `INT_WORDS` (default 0x1000) asserts `int_req` with `int_addr` equal to `fetch_addr`. `fetch_ready` follows `int_ready` and `fetch_data` follows `int_rdata`. `ext_req` stays low, and the cache contents and recency order are unchanged.
- R2: An external fetch whose block is held in a valid segment, with the word's present bit set, raises `fetch_ready` in the cycle it is presented, with the stored word on `fetch_data`. No external request is made.
- R3: An external fetch that misses keeps `fetch_ready` and `ext_req` low in its first cycle. From the next cycle, `ext_req` is high and `fetch_ready` equals `ext_ready`. `fetch_data` carries `ext_rdata` in the cycle `ext_ready` is high.
- R4: A word returned by a miss is written into the cache. A later fetch of the same address hits and returns that word, even if external memory has since changed.
- R5: A miss on a word whose block tag matches a segment, with that word not present, fills the word into that segment. The segment's other present words keep their contents.
- R6: Allocating a segment for a new block clears all its present bits, writes the new tag, and marks only the fetched word. Words of the block that was there before then miss.
- R7: The segment reused for a new block is the least recently used one that is not frozen. Every hit and every fill makes the touched segment the most recently used.
- R8: A segment whose `freeze` bit is high is never reused for a new block, and it still serves hits.
- R9: When all four `freeze` bits are high, a miss on a new block is served from external memory and nothing is cached.
- R10: A one-cycle `clear` empties every segment, including frozen ones. It resets the recency order to segment 0 as oldest through segment 3 as newest. A fill that coincides with `clear` is dropped.
- R11: While `ext_req` is high and `ext_ready` is low, the next cycle keeps `ext_req` high with the same `ext_addr`.
- R12: After reset, with no fetch presented, `fetch_ready`, `ext_req` and `int_req` are low and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | CPU fetch request, held until `fetch_ready` |
| fetch_addr | input | AW | Word address of the fetch |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_data | output | DW | Instruction word returned |
| freeze | input | NSEG | Per-segment freeze; a frozen segment is not replaced |
| clear | input | 1 | Invalidate the whole cache |
| int_req | output | 1 | Internal memory read request |
| int_addr | output | AW | Internal memory address |
| int_ready | input | 1 | Internal memory data valid |
| int_rdata | input | DW | Internal memory read data |
| ext_req | output | 1 | External memory read request |
| ext_addr | output | AW | External memory address |
| ext_ready | input | 1 | External memory data valid |
| ext_rdata | input | DW | External memory read data |

## Verification
The hardest case to reach from the ports is reuse of a segment that is neither the lowest-numbered nor the most recently filled. The bench creates it by filling all four segments, then hitting an older block so the recency order no longer matches the fill order. The next new block must then evict the segment the order names, and the earlier block fetched again must miss.

Freeze patterns are changed between misses to check that frozen blocks keep hitting while the others rotate. All four segments are then frozen to show that misses stop allocating. Finally, a clear is applied while everything is frozen, and the bench refills four blocks to expose the reset recency order.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [0:0] {
        ST_LOOKUP = 1'b0,
        ST_REFILL = 1'b1
    } ic_state_t;

endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
    parameter int AW   = 24,
    parameter int NSEG = 4,
    parameter int WPS  = 32,
    localparam int OFFW = $clog2(WPS),
    localparam int TW   = AW - OFFW,
    localparam int SW   = $clog2(NSEG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [AW-1:0]   look_addr,
    input  logic            wr_en,
    input  logic            wr_alloc,
    input  logic [SW-1:0]   wr_seg,
    output logic            hit,
    output logic [SW-1:0]   hit_seg,
    output logic            tag_match,
    output logic [SW-1:0]   match_seg,
    output logic [NSEG-1:0] seg_valid
);

    logic [TW-1:0]   look_tag;
    logic [OFFW-1:0] look_off;
    logic [TW-1:0]   tag_q  [NSEG];
    logic [WPS-1:0]  pres_q [NSEG];
    logic [NSEG-1:0] valid_q;
    logic [NSEG-1:0] match_vec;

    assign look_tag  = look_addr[AW-1:OFFW];
    assign look_off  = look_addr[OFFW-1:0];
    assign seg_valid = valid_q;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign match_vec[s] = valid_q[s] && (tag_q[s] == look_tag);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[s] <= 1'b0;
                tag_q[s]   <= '0;
                pres_q[s]  <= '0;
            end else if (clear) begin
                valid_q[s] <= 1'b0;
                pres_q[s]  <= '0;
            end else if (wr_en && (wr_seg == SW'(s))) begin
                if (wr_alloc) begin
                    valid_q[s] <= 1'b1;
                    tag_q[s]   <= look_tag;
                    pres_q[s]  <= WPS'(1) << look_off;
                end else begin
                    pres_q[s][look_off] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        tag_match = 1'b0;
        match_seg = '0;
        for (int s = 0; s < NSEG; s++) begin
            if (match_vec[s]) begin
                tag_match = 1'b1;
                match_seg = SW'(s);
            end
        end
        hit     = tag_match && pres_q[match_seg][look_off];
        hit_seg = match_seg;
    end

endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
    parameter int NSEG = 4,
    localparam int SW  = $clog2(NSEG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            touch_en,
    input  logic [SW-1:0]   touch_seg,
    input  logic [NSEG-1:0] freeze,
    output logic            victim_ok,
    output logic [SW-1:0]   victim_seg
);

    // rank 0 = oldest, NSEG-1 = newest
    logic [SW-1:0] rank_q [NSEG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSEG; s++) rank_q[s] <= SW'(s);
        end else if (clear) begin
            for (int s = 0; s < NSEG; s++) rank_q[s] <= SW'(s);
        end else if (touch_en) begin
            for (int s = 0; s < NSEG; s++) begin
                if (SW'(s) == touch_seg)
                    rank_q[s] <= SW'(NSEG - 1);
                else if (rank_q[s] > rank_q[touch_seg])
                    rank_q[s] <= rank_q[s] - 1'b1;
            end
        end
    end

    always_comb begin
        logic [SW-1:0] best;
        victim_ok  = 1'b0;
        victim_seg = '0;
        best       = '1;
        for (int s = 0; s < NSEG; s++) begin
            if (!freeze[s] && (!victim_ok || rank_q[s] < best)) begin
                victim_ok  = 1'b1;
                victim_seg = SW'(s);
                best       = rank_q[s];
            end
        end
    end

endmodule

// File: rtl/icache_data.sv
module icache_data #(
    parameter int DW   = 32,
    parameter int NSEG = 4,
    parameter int WPS  = 32,
    localparam int DEPTH = NSEG * WPS,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/icache_seg.sv
module icache_seg
    import icache_pkg::*;
#(
    parameter int AW        = 24,
    parameter int DW        = 32,
    parameter int NSEG      = 4,
    parameter int WPS       = 32,
    parameter int INT_WORDS = 4096,
    localparam int OFFW = $clog2(WPS),
    localparam int SW   = $clog2(NSEG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [AW-1:0]   fetch_addr,
    output logic            fetch_ready,
    output logic [DW-1:0]   fetch_data,
    input  logic [NSEG-1:0] freeze,
    input  logic            clear,
    output logic            int_req,
    output logic [AW-1:0]   int_addr,
    input  logic            int_ready,
    input  logic [DW-1:0]   int_rdata,
    output logic            ext_req,
    output logic [AW-1:0]   ext_addr,
    input  logic            ext_ready,
    input  logic [DW-1:0]   ext_rdata
);

    localparam logic [AW-1:0] INT_LIM = AW'(INT_WORDS);

    ic_state_t       state_q, state_d;
    logic [AW-1:0]   miss_addr_q;
    logic [AW-1:0]   look_addr;
    logic            is_int;
    logic            hit, tag_match, victim_ok;
    logic [SW-1:0]   hit_seg, match_seg, victim_seg;
    logic [NSEG-1:0] seg_valid;
    logic            wr_en, wr_alloc, alloc_we, touch_en;
    logic [SW-1:0]   wr_seg, touch_seg;
    logic [DW-1:0]   cache_rdata;

    assign is_int    = fetch_addr < INT_LIM;
    assign look_addr = (state_q == ST_REFILL) ? miss_addr_q : fetch_addr;
    assign int_addr  = fetch_addr;
    assign ext_addr  = miss_addr_q;
    assign alloc_we  = wr_en && wr_alloc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_LOOKUP;
            miss_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOOKUP && state_d == ST_REFILL)
                miss_addr_q <= fetch_addr;
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        fetch_ready = 1'b0;
        fetch_data  = cache_rdata;
        int_req     = 1'b0;
        ext_req     = 1'b0;
        wr_en       = 1'b0;
        wr_alloc    = 1'b0;
        wr_seg      = match_seg;
        touch_en    = 1'b0;
        touch_seg   = hit_seg;
        unique case (state_q)
            ST_LOOKUP: begin
                if (fetch_valid && is_int) begin
                    int_req     = 1'b1;
                    fetch_ready = int_ready;
                    fetch_data  = int_rdata;
                end else if (fetch_valid && hit) begin
                    fetch_ready = 1'b1;
                    touch_en    = !clear;
                end else if (fetch_valid) begin
                    state_d = ST_REFILL;
                end
            end
            ST_REFILL: begin
                ext_req     = 1'b1;
                fetch_ready = ext_ready;
                fetch_data  = ext_rdata;
                if (ext_ready) begin
                    state_d = ST_LOOKUP;
                    if (tag_match) begin
                        wr_en = !clear;
                    end else if (victim_ok) begin
                        wr_en    = !clear;
                        wr_alloc = 1'b1;
                        wr_seg   = victim_seg;
                    end
                    touch_en  = wr_en;
                    touch_seg = wr_seg;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    icache_tags #(.AW(AW), .NSEG(NSEG), .WPS(WPS)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .look_addr (look_addr),
        .wr_en     (wr_en),
        .wr_alloc  (wr_alloc),
        .wr_seg    (wr_seg),
        .hit       (hit),
        .hit_seg   (hit_seg),
        .tag_match (tag_match),
        .match_seg (match_seg),
        .seg_valid (seg_valid)
    );

    icache_lru #(.NSEG(NSEG)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .touch_en   (touch_en),
        .touch_seg  (touch_seg),
        .freeze     (freeze),
        .victim_ok  (victim_ok),
        .victim_seg (victim_seg)
    );

    icache_data #(.DW(DW), .NSEG(NSEG), .WPS(WPS)) u_data (
        .clk   (clk),
        .we    (wr_en),
        .waddr ({wr_seg, look_addr[OFFW-1:0]}),
        .wdata (ext_rdata),
        .raddr ({hit_seg, look_addr[OFFW-1:0]}),
        .rdata (cache_rdata)
    );

endmodule

// File: rtl/icache_seg_chk.sv
module icache_seg_chk #(
    parameter int AW   = 24,
    parameter int NSEG = 4,
    localparam int SW  = $clog2(NSEG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clear,
    input logic [NSEG-1:0] freeze,
    input logic            fetch_valid,
    input logic            fetch_ready,
    input logic            int_req,
    input logic            ext_req,
    input logic            ext_ready,
    input logic [AW-1:0]   ext_addr,
    input logic            alloc_we,
    input logic [SW-1:0]   wr_seg,
    input logic [NSEG-1:0] seg_valid
);

    // R1
    bypass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> !ext_req);

    // R3
    miss_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> (fetch_ready == ext_ready));

    // R3
    miss_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_req) |-> ($past(fetch_valid) && !$past(fetch_ready)));

    // R11
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ready) |=> (ext_req && $stable(ext_addr)));

    // R8
    frozen_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_we |-> !freeze[wr_seg]);

    // R9
    all_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&freeze) |-> !alloc_we);

    // R10
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (seg_valid == '0));

endmodule

bind icache_seg icache_seg_chk #(.AW(AW), .NSEG(NSEG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .freeze      (freeze),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .int_req     (int_req),
    .ext_req     (ext_req),
    .ext_ready   (ext_ready),
    .ext_addr    (ext_addr),
    .alloc_we    (alloc_we),
    .wr_seg      (wr_seg),
    .seg_valid   (seg_valid)
);

// File: tb/sim_icache_seg.sv
module sim_icache_seg;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 32;
    localparam int NSEG = 4;
    localparam int WPS = 32;
    localparam int INT_WORDS = 4096;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_valid = 1'b0;
    logic [AW-1:0]   fetch_addr = '0;
    logic            fetch_ready;
    logic [DW-1:0]   fetch_data;
    logic [NSEG-1:0] freeze = '0;
    logic            clear = 1'b0;
    logic            int_req;
    logic [AW-1:0]   int_addr;
    logic            int_ready = 1'b0;
    logic [DW-1:0]   int_rdata = '0;
    logic            ext_req;
    logic [AW-1:0]   ext_addr;
    logic            ext_ready = 1'b0;
    logic [DW-1:0]   ext_rdata = '0;

    icache_seg #(.AW(AW), .DW(DW), .NSEG(NSEG), .WPS(WPS), .INT_WORDS(INT_WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_data(fetch_data), .freeze(freeze), .clear(clear),
        .int_req(int_req), .int_addr(int_addr), .int_ready(int_ready), .int_rdata(int_rdata),
        .ext_req(ext_req), .ext_addr(ext_addr), .ext_ready(ext_ready), .ext_rdata(ext_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int gen = 1;
    bit finished = 1'b0;

    // behavioural model: block tags, present words, data, recency queue
    bit            m_valid [NSEG];
    int            m_tag   [NSEG];
    bit            m_pres  [NSEG][WPS];
    logic [DW-1:0] m_data  [NSEG][WPS];
    int            lru_q[$];

    function automatic logic [DW-1:0] ext_word(input logic [AW-1:0] a);
        return {gen[7:0], a};
    endfunction

    function automatic logic [DW-1:0] int_word(input logic [AW-1:0] a);
        return {8'hC3, a};
    endfunction

    function automatic void m_reset();
        for (int s = 0; s < NSEG; s++) begin
            m_valid[s] = 1'b0;
            for (int w = 0; w < WPS; w++) m_pres[s][w] = 1'b0;
        end
        lru_q = {};
        for (int s = 0; s < NSEG; s++) lru_q.push_back(s);
    endfunction

    function automatic int m_find(input logic [AW-1:0] a);
        for (int s = 0; s < NSEG; s++)
            if (m_valid[s] && m_tag[s] == int'(a >> 5)) return s;
        return -1;
    endfunction

    function automatic void m_touch(input int s);
        for (int i = 0; i < lru_q.size(); i++) begin
            if (lru_q[i] == s) begin
                lru_q.delete(i);
                break;
            end
        end
        lru_q.push_back(s);
    endfunction

    function automatic void m_fill(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int s;
        int w;
        s = m_find(a);
        w = int'(a[4:0]);
        if (s < 0) begin
            for (int i = 0; i < lru_q.size(); i++) begin
                if (!freeze[lru_q[i]]) begin
                    s = lru_q[i];
                    break;
                end
            end
            if (s >= 0) begin
                m_valid[s] = 1'b1;
                m_tag[s]   = int'(a >> 5);
                for (int k = 0; k < WPS; k++) m_pres[s][k] = 1'b0;
            end
        end
        if (s >= 0) begin
            m_pres[s][w] = 1'b1;
            m_data[s][w] = d;
            m_touch(s);
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [AW-1:0] a, input int dly, input string tag);
        int  s;
        int  k;
        bit  hit;
        logic [DW-1:0] d;
        s   = m_find(a);
        hit = (s >= 0) && m_pres[s][a[4:0]];
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        if (a < AW'(INT_WORDS)) begin
            k = 0;
            forever begin
                int_ready = (k >= dly);
                int_rdata = int_word(a);
                #1;
                chk(int_req && !ext_req && int_addr == a, tag, "internal routing",
                    {int_req, ext_req, int_addr}, {2'b10, a});
                chk(fetch_ready == int_ready, tag, "fetch_ready internal", fetch_ready, int_ready);
                if (fetch_ready) begin
                    chk(fetch_data == int_word(a), tag, "internal data", fetch_data, int_word(a));
                    break;
                end
                @(negedge clk);
                k++;
            end
        end else if (hit) begin
            #1;
            chk(fetch_ready && !ext_req, tag, "hit in one cycle", {fetch_ready, ext_req}, 2'b10);
            chk(fetch_data == m_data[s][a[4:0]], tag, "hit data", fetch_data, m_data[s][a[4:0]]);
            m_touch(s);
        end else begin
            #1;
            chk(!fetch_ready && !ext_req, tag, "miss first cycle", {fetch_ready, ext_req}, 2'b00);
            k = 0;
            forever begin
                @(negedge clk);
                k++;
                ext_ready = (k - 1 >= dly);
                ext_rdata = ext_word(a);
                #1;
                // R11: request held with a stable address until ready
                chk(ext_req && ext_addr == a, "R11", "ext request", {ext_req, ext_addr}, {1'b1, a});
                chk(fetch_ready == ext_ready, tag, "fetch_ready miss", fetch_ready, ext_ready);
                if (ext_ready) begin
                    d = ext_word(a);
                    chk(fetch_data == d, tag, "miss data", fetch_data, d);
                    m_fill(a, d);
                    break;
                end
            end
        end
        @(negedge clk);
        fetch_valid = 1'b0;
        ext_ready   = 1'b0;
        int_ready   = 1'b0;
        gen++;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        m_reset();
    endtask

    function automatic logic [AW-1:0] blk(input int n, input int w);
        return AW'(32'h1000 + n * 32 + w);
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12
        chk(!fetch_ready && !ext_req && !int_req, "R12", "reset outputs",
            {fetch_ready, ext_req, int_req}, 3'b000);

        do_fetch(24'h000010, 2, "R1");
        do_fetch(24'h000010, 0, "R1");
        do_fetch(24'h000FFF, 1, "R1");

        do_fetch(blk(0, 3), 1, "R3");
        do_fetch(blk(0, 3), 0, "R2");
        do_fetch(blk(0, 3), 0, "R4");

        do_fetch(blk(0, 7), 0, "R5");
        do_fetch(blk(0, 3), 0, "R5");
        do_fetch(blk(0, 7), 0, "R5");

        do_fetch(blk(1, 0), 2, "R3");
        do_fetch(blk(2, 0), 3, "R3");
        do_fetch(blk(3, 0), 0, "R3");

        do_fetch(blk(0, 3), 0, "R7");
        do_fetch(blk(4, 0), 1, "R7");
        do_fetch(blk(2, 0), 0, "R7");
        do_fetch(blk(1, 0), 0, "R6");
        do_fetch(blk(3, 0), 0, "R6");
        do_fetch(blk(0, 3), 0, "R7");

        freeze = 4'b0101;
        for (int n = 5; n < 9; n++) do_fetch(blk(n, 1), 1, "R8");
        for (int n = 0; n < 9; n++) do_fetch(blk(n, 1), 0, "R8");
        do_fetch(blk(0, 3), 0, "R8");

        freeze = 4'b1111;
        do_fetch(blk(9, 2), 0, "R9");
        do_fetch(blk(9, 2), 1, "R9");

        do_clear();
        freeze = 4'b0000;
        do_fetch(blk(0, 3), 0, "R10");
        do_fetch(blk(10, 0), 0, "R10");
        do_fetch(blk(11, 0), 0, "R10");
        do_fetch(blk(12, 0), 0, "R10");
        freeze = 4'b0010;
        do_fetch(blk(13, 0), 0, "R10");
        do_fetch(blk(0, 3), 0, "R10");
        do_fetch(blk(11, 0), 0, "R10");

        do_fetch(blk(14, 5), 4, "R11");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule